// File: doc/BRIEF.md
# Work-Farm Reconfiguration Dispatcher

This block sits at the centre of a farm of worker slots. It takes one stream of work items and hands each item to a worker as a packet. At any moment it can also accept a request to reconfigure one worker with one of several configuration images that it keeps internally. Once it accepts such a request, the named worker is pulled out of the work rotation. The dispatcher then streams the image to that worker packet by packet and waits for the worker to report back with its own ID. When that ID arrives, the worker returns to the rotation. Work keeps flowing to every other worker the whole time.

Each outgoing packet is 16 bits. The top bit marks the packet as work or configuration. The dispatcher times each reconfiguration, starting when the worker accepts the first configuration packet and ending when the completion ID arrives. It keeps the result, and the worker it belongs to, on output registers until the next reconfiguration finishes. An ID that comes back when nothing is waiting for it, or that carries the wrong value, changes nothing except a sticky error flag.

Top module: `workfarm_dispatcher`

## Requirements
- R1: After reset the outputs are as follows. No packet is valid. `cfgReqReady` is 1. `idError` is 0. `lastCycles` and `lastWorker` are 0. All workers are in rotation, so `workReady` is 1.
- R2: Bit 15 of every packet is the type bit: 0 marks work and 1 marks configuration. A work packet is `{1'b0, workData}` and is presented on exactly one worker channel.
- R3: Work goes to the workers in rotation in strict circular order. After reset the first item goes to worker 0, and each later item goes to the next worker in rotation after the one that received the previous item.
- R4: When a worker channel shows a valid packet and its ready is low, the packet stays valid with unchanged data on the next cycle.
- R5: A reconfiguration request is accepted only while no reconfiguration is in progress. `cfgReqReady` is low from the cycle after an acceptance until the matching completion ID has been received.
- R6: A reconfiguration sends exactly 8 configuration packets to the target worker, index 0 first and index 7 last. Packet i of image g is `{1'b1, ((g*8 + i) XOR 15'h2A00)}`.
- R7: From the cycle a request is accepted, the target worker is removed from the rotation. It receives no new work packet until its completion ID has been accepted.
- R8: An ID equal to the target's index that arrives on the target's channel after all 8 packets have been sent completes the reconfiguration. The worker then rejoins the rotation at its place in the circular order.
- R9: `workReady` is low while the next worker in rotation still holds a packet that it has not accepted.
- R10: An ID that arrives on the wrong channel, carries the wrong value, or arrives while no completion is awaited is ignored. It sets `idError`, which stays set until reset.
- R11: On completion, `lastCycles` becomes the number of clock cycles from the edge on which the target accepted its first configuration packet to the edge on which the completion ID was taken. `lastWorker` becomes the target. Both values hold until the next completion.
- R12: While one worker is being reconfigured, the other workers keep receiving work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| workValid | input | 1 | Work item offered |
| workReady | output | 1 | Work item taken on this edge |
| workData | input | 15 | Work payload |
| cfgReqValid | input | 1 | Reconfiguration request offered |
| cfgReqReady | output | 1 | Request can be accepted |
| cfgReqWorker | input | 2 | Worker to reconfigure |
| cfgReqImage | input | 2 | Stored image to send |
| pktValid | output | 4 | Per-worker packet valid |
| pktReady | input | 4 | Per-worker packet ready |
| pktData | output | 64 | Per-worker packet, worker w in bits 16w+15..16w |
| idValid | input | 4 | Per-worker completion ID valid |
| idData | input | 8 | Per-worker returned ID, worker w in bits 2w+1..2w |
| lastCycles | output | 32 | Duration of the latest completed reconfiguration |
| lastWorker | output | 2 | Worker of the latest completed reconfiguration |
| idError | output | 1 | Sticky flag for an ignored ID |

## Verification
Some rules are checked by the assertions on every cycle. A stalled packet must be held (R4). The request port must close after an acceptance (R5). A worker under reconfiguration must never be handed a fresh work packet (R7). The error flag must stay set (R10). The measurement registers must stay quiet when no ID arrives (R11). Other behaviour can only be shown by the bench scenarios. These include the circular order and the skipping of the excluded worker, the content and order of the image packets, the exact cycle count of a reconfiguration, and the worker rejoining at the right place in the order.

// File: rtl/wfd_pkg.sv
package wfd_pkg;
  localparam int NUM_WORKERS = 4;
  localparam int NUM_IMAGES  = 4;
  localparam int IMAGE_LEN   = 8;
  localparam int PKT_W       = 16;
  localparam int CNT_W       = 32;

  localparam int WID_W = $clog2(NUM_WORKERS);
  localparam int IMG_W = $clog2(NUM_IMAGES);
  localparam int IDX_W = $clog2(IMAGE_LEN);
  localparam int PAY_W = PKT_W - 1;

  localparam logic [PAY_W-1:0] IMG_SALT = PAY_W'('h2A00);

  typedef struct packed {
    logic             acceptReq;
    logic             loadCfg;
    logic             startCnt;
    logic             runCnt;
    logic             doneOk;
    logic             badId;
    logic [WID_W-1:0] tgt;
    logic [IMG_W-1:0] img;
    logic [IDX_W-1:0] idx;
  } ctlStrobes_t;

  // stored configuration images are computed, not loaded
  function automatic logic [PKT_W-1:0] imageWord(input logic [IMG_W-1:0] img,
                                                 input logic [IDX_W-1:0] idx);
    logic [PAY_W-1:0] pay;
    pay = PAY_W'(int'(img) * IMAGE_LEN + int'(idx));
    return {1'b1, pay ^ IMG_SALT};
  endfunction
endpackage

// File: rtl/wfd_ctrl.sv
module wfd_ctrl
  import wfd_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgReqValid,
  input  logic [WID_W-1:0]             cfgReqWorker,
  input  logic [IMG_W-1:0]             cfgReqImage,
  input  logic                         tgtSlotFree,
  input  logic                         tgtCfgSent,
  input  logic [NUM_WORKERS-1:0]       idValid,
  input  logic [NUM_WORKERS*WID_W-1:0] idData,
  output logic                         cfgReqReady,
  output ctlStrobes_t                  ctl
);
  typedef enum logic [1:0] {ST_IDLE, ST_STREAM, ST_WAIT} state_t;

  state_t           state;
  logic [WID_W-1:0] tgtQ;
  logic [IMG_W-1:0] imgQ;
  logic [IDX_W-1:0] idxQ;
  logic             firstPend;
  logic             counting;

  always_comb begin
    ctl           = '0;
    ctl.tgt       = tgtQ;
    ctl.img       = imgQ;
    ctl.idx       = idxQ;
    cfgReqReady   = (state == ST_IDLE);
    ctl.acceptReq = cfgReqReady && cfgReqValid;
    ctl.loadCfg   = (state == ST_STREAM) && tgtSlotFree;
    ctl.startCnt  = firstPend && tgtCfgSent;
    ctl.runCnt    = counting;
    for (int w = 0; w < NUM_WORKERS; w++) begin
      if (idValid[w]) begin
        if ((state == ST_WAIT) && (WID_W'(w) == tgtQ) &&
            (idData[w*WID_W +: WID_W] == tgtQ))
          ctl.doneOk = 1'b1;
        else
          ctl.badId = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tgtQ      <= '0;
      imgQ      <= '0;
      idxQ      <= '0;
      firstPend <= 1'b0;
      counting  <= 1'b0;
    end else begin
      if (ctl.startCnt) begin
        firstPend <= 1'b0;
        counting  <= 1'b1;
      end
      case (state)
        ST_IDLE: if (ctl.acceptReq) begin
          tgtQ      <= cfgReqWorker;
          imgQ      <= cfgReqImage;
          idxQ      <= '0;
          firstPend <= 1'b1;
          state     <= ST_STREAM;
        end
        ST_STREAM: if (ctl.loadCfg) begin
          idxQ <= idxQ + 1'b1;
          if (idxQ == IDX_W'(IMAGE_LEN - 1)) state <= ST_WAIT;
        end
        ST_WAIT: if (ctl.doneOk) begin
          counting <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wfd_dpath.sv
module wfd_dpath
  import wfd_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobes_t                  ctl,
  input  logic [WID_W-1:0]             cfgReqWorker,
  input  logic                         workValid,
  input  logic [PAY_W-1:0]             workData,
  output logic                         workReady,
  input  logic [NUM_WORKERS-1:0]       pktReady,
  output logic [NUM_WORKERS-1:0]       pktValid,
  output logic [NUM_WORKERS*PKT_W-1:0] pktData,
  output logic                         tgtSlotFree,
  output logic                         tgtCfgSent,
  output logic [CNT_W-1:0]             lastCycles,
  output logic [WID_W-1:0]             lastWorker,
  output logic                         idError
);
  logic [NUM_WORKERS-1:0] slotValid;
  logic [PKT_W-1:0]       slotData [NUM_WORKERS];
  logic [NUM_WORKERS-1:0] inRot;
  logic [NUM_WORKERS-1:0] reqMask;
  logic [NUM_WORKERS-1:0] effRot;
  logic [WID_W-1:0]       rrPtr;
  logic [WID_W-1:0]       nextW;
  logic                   found;
  logic                   workTake;
  logic [CNT_W-1:0]       cnt;

  always_comb begin
    reqMask = ctl.acceptReq ? (NUM_WORKERS'(1) << cfgReqWorker) : '0;
    effRot  = inRot & ~reqMask;
    found   = 1'b0;
    nextW   = '0;
    for (int k = 0; k < NUM_WORKERS; k++) begin
      logic [WID_W-1:0] cand;
      cand = WID_W'((int'(rrPtr) + k) % NUM_WORKERS);
      if (!found && effRot[cand]) begin
        found = 1'b1;
        nextW = cand;
      end
    end
    workReady   = found && !slotValid[nextW];
    workTake    = workValid && workReady;
    tgtSlotFree = !slotValid[ctl.tgt];
    tgtCfgSent  = slotValid[ctl.tgt] && pktReady[ctl.tgt] && slotData[ctl.tgt][PKT_W-1];
  end

  for (genvar w = 0; w < NUM_WORKERS; w++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[w] <= 1'b0;
        slotData[w]  <= '0;
      end else if (ctl.loadCfg && (ctl.tgt == WID_W'(w))) begin
        slotValid[w] <= 1'b1;
        slotData[w]  <= imageWord(ctl.img, ctl.idx);
      end else if (workTake && (nextW == WID_W'(w))) begin
        slotValid[w] <= 1'b1;
        slotData[w]  <= {1'b0, workData};
      end else if (pktReady[w]) begin
        slotValid[w] <= 1'b0;
      end
    end
    assign pktValid[w]                = slotValid[w];
    assign pktData[w*PKT_W +: PKT_W]  = slotData[w];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inRot      <= '1;
      rrPtr      <= '0;
      cnt        <= '0;
      lastCycles <= '0;
      lastWorker <= '0;
      idError    <= 1'b0;
    end else begin
      inRot <= effRot | (ctl.doneOk ? (NUM_WORKERS'(1) << ctl.tgt) : '0);
      if (workTake) rrPtr <= WID_W'((int'(nextW) + 1) % NUM_WORKERS);
      if (ctl.startCnt)    cnt <= CNT_W'(1);
      else if (ctl.runCnt) cnt <= cnt + 1'b1;
      if (ctl.doneOk) begin
        lastCycles <= cnt;
        lastWorker <= ctl.tgt;
      end
      if (ctl.badId) idError <= 1'b1;
    end
  end
endmodule

// File: rtl/workfarm_dispatcher.sv
module workfarm_dispatcher
  import wfd_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         workValid,
  output logic                         workReady,
  input  logic [PAY_W-1:0]             workData,
  input  logic                         cfgReqValid,
  output logic                         cfgReqReady,
  input  logic [WID_W-1:0]             cfgReqWorker,
  input  logic [IMG_W-1:0]             cfgReqImage,
  output logic [NUM_WORKERS-1:0]       pktValid,
  input  logic [NUM_WORKERS-1:0]       pktReady,
  output logic [NUM_WORKERS*PKT_W-1:0] pktData,
  input  logic [NUM_WORKERS-1:0]       idValid,
  input  logic [NUM_WORKERS*WID_W-1:0] idData,
  output logic [CNT_W-1:0]             lastCycles,
  output logic [WID_W-1:0]             lastWorker,
  output logic                         idError
);
  ctlStrobes_t ctl;
  logic        tgtSlotFree;
  logic        tgtCfgSent;

  wfd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgReqValid(cfgReqValid), .cfgReqWorker(cfgReqWorker), .cfgReqImage(cfgReqImage),
    .tgtSlotFree(tgtSlotFree), .tgtCfgSent(tgtCfgSent),
    .idValid(idValid), .idData(idData),
    .cfgReqReady(cfgReqReady), .ctl(ctl)
  );

  wfd_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgReqWorker(cfgReqWorker),
    .workValid(workValid), .workData(workData), .workReady(workReady),
    .pktReady(pktReady), .pktValid(pktValid), .pktData(pktData),
    .tgtSlotFree(tgtSlotFree), .tgtCfgSent(tgtCfgSent),
    .lastCycles(lastCycles), .lastWorker(lastWorker), .idError(idError)
  );
endmodule

// File: rtl/workfarm_dispatcher_chk.sv
module workfarm_dispatcher_chk
  import wfd_pkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic                         cfgReqValid,
  input logic                         cfgReqReady,
  input logic [WID_W-1:0]             cfgReqWorker,
  input logic [NUM_WORKERS-1:0]       pktValid,
  input logic [NUM_WORKERS-1:0]       pktReady,
  input logic [NUM_WORKERS*PKT_W-1:0] pktData,
  input logic [NUM_WORKERS-1:0]       idValid,
  input logic [CNT_W-1:0]             lastCycles,
  input logic                         idError
);
  logic [NUM_WORKERS-1:0] busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) busyQ <= '0;
    else if (cfgReqValid && cfgReqReady) busyQ <= NUM_WORKERS'(1) << cfgReqWorker;
    else if (cfgReqReady) busyQ <= '0;
  end

  for (genvar w = 0; w < NUM_WORKERS; w++) begin : g_chk
    p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      pktValid[w] && !pktReady[w] |=> pktValid[w] && $stable(pktData[w*PKT_W +: PKT_W]));

    p_no_work_r7: assert property (@(posedge clk) disable iff (!rstN)
      busyQ[w] && pktValid[w] && (!$past(pktValid[w]) || $past(pktReady[w]))
      |-> pktData[w*PKT_W + PKT_W - 1]);
  end

  p_req_closed_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid && cfgReqReady |=> !cfgReqReady);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    idError |=> idError);

  p_meas_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(|idValid) |=> $stable(lastCycles));
endmodule

bind workfarm_dispatcher workfarm_dispatcher_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgReqValid(cfgReqValid), .cfgReqReady(cfgReqReady),
  .cfgReqWorker(cfgReqWorker), .pktValid(pktValid), .pktReady(pktReady),
  .pktData(pktData), .idValid(idValid), .lastCycles(lastCycles), .idError(idError)
);

// File: tb/tb_workfarm_dispatcher.sv
module tb_workfarm_dispatcher;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        workValid = 1'b0;
  logic        workReady;
  logic [14:0] workData = '0;
  logic        cfgReqValid = 1'b0;
  logic        cfgReqReady;
  logic [1:0]  cfgReqWorker = '0;
  logic [1:0]  cfgReqImage = '0;
  logic [3:0]  pktValid;
  logic [3:0]  pktReady = 4'hF;
  logic [63:0] pktData;
  logic [3:0]  idValid = '0;
  logic [7:0]  idData = '0;
  logic [31:0] lastCycles;
  logic [1:0]  lastWorker;
  logic        idError;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int firstCfgCyc = -1;
  int idCyc = 0;
  int logN [4] = '{0, 0, 0, 0};
  int expN [4] = '{0, 0, 0, 0};
  logic [15:0] logD [4][64];

  // entries: {expected worker, payload}
  localparam logic [16:0] WORK_TBL [8] = '{
    {2'd0, 15'h0101}, {2'd1, 15'h7FFF}, {2'd2, 15'h0000}, {2'd3, 15'h1234},
    {2'd0, 15'h5555}, {2'd1, 15'h2AAA}, {2'd2, 15'h0F0F}, {2'd3, 15'h7001}
  };

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  workfarm_dispatcher dut (
    .clk(clk), .rstN(rstN), .workValid(workValid), .workReady(workReady),
    .workData(workData), .cfgReqValid(cfgReqValid), .cfgReqReady(cfgReqReady),
    .cfgReqWorker(cfgReqWorker), .cfgReqImage(cfgReqImage), .pktValid(pktValid),
    .pktReady(pktReady), .pktData(pktData), .idValid(idValid), .idData(idData),
    .lastCycles(lastCycles), .lastWorker(lastWorker), .idError(idError)
  );

  // handshake logger, samples 2 ns before each rising edge
  always begin
    @(negedge clk);
    #3;
    for (int w = 0; w < 4; w++) begin
      if (pktValid[w] && pktReady[w]) begin
        if (logN[w] < 64) logD[w][logN[w]] = pktData[w*16 +: 16];
        logN[w]++;
        if (pktData[w*16 + 15] && firstCfgCyc < 0) firstCfgCyc = cyc;
      end
    end
  end

  function automatic logic [15:0] imgWord(int g, int i);
    logic [14:0] p;
    p = 15'(g * 8 + i);
    return {1'b1, p ^ 15'h2A00};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic sendWork(input logic [14:0] d);
    step();
    workValid = 1'b1;
    workData  = d;
    #2;
    while (!workReady) begin @(negedge clk); #3; end
    step();
    workValid = 1'b0;
  endtask

  task automatic sendWorkChk(input logic [14:0] d, input int w, input string req);
    sendWork(d);
    expN[w]++;
    #3;
    chk(logN[w] == expN[w], req, 32'(logN[w]), 32'(expN[w]));
    chk(logD[w][logN[w]-1] == {1'b0, d}, req, 32'(logD[w][logN[w]-1]), 32'({1'b0, d}));
  endtask

  task automatic sendId(input int ch, input logic [1:0] v);
    step();
    idValid     = 4'b0001 << ch;
    idData      = 8'(v) << (2 * ch);
    #2;
    idCyc = cyc;
    step();
    idValid = '0;
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    rstN = 1'b1;
    #2;
    // R1 reset state
    chk(pktValid == 4'h0, "R1 pktValid", 32'(pktValid), 0);
    chk(cfgReqReady == 1'b1, "R1 cfgReqReady", 32'(cfgReqReady), 1);
    chk(idError == 1'b0, "R1 idError", 32'(idError), 0);
    chk(lastCycles == 0 && lastWorker == 0, "R1 measure", lastCycles, 0);
    chk(workReady == 1'b1, "R1 workReady", 32'(workReady), 1);

    // R2 R3 circular order from the table
    for (int i = 0; i < 8; i++)
      sendWorkChk(WORK_TBL[i][14:0], int'(WORK_TBL[i][16:15]), "R2/R3 table");

    // R4 hold on stall, R9 input stall
    step();
    pktReady[1] = 1'b0;
    sendWorkChk(15'h0A0A, 0, "R3 after table");
    sendWork(15'h0B0B);
    #3;
    chk(pktValid[1] && pktData[31:16] == 16'h0B0B, "R4 held", 32'(pktData[31:16]), 32'h0B0B);
    for (int i = 0; i < 2; i++) begin
      step(); #2;
      chk(pktValid[1] && pktData[31:16] == 16'h0B0B, "R4 stable", 32'(pktData[31:16]), 32'h0B0B);
    end
    sendWorkChk(15'h0C0C, 2, "R3 continue");
    sendWorkChk(15'h0D0D, 3, "R3 continue");
    sendWorkChk(15'h0E0E, 0, "R3 wrap");
    step();
    workValid = 1'b1;
    workData  = 15'h0F0F;
    #2;
    chk(workReady == 1'b0, "R9 stall", 32'(workReady), 0);
    step(); #2;
    chk(workReady == 1'b0, "R9 stall hold", 32'(workReady), 0);
    step();
    pktReady[1] = 1'b1;
    #2;
    while (!workReady) begin @(negedge clk); #3; end
    step();
    workValid = 1'b0;
    expN[1] += 2;
    #3;
    chk(logN[1] == expN[1], "R9 release count", 32'(logN[1]), 32'(expN[1]));
    chk(logD[1][logN[1]-1] == 16'h0F0F, "R9 release data", 32'(logD[1][logN[1]-1]), 32'h0F0F);

    // reconfiguration of worker 2 with image 1
    firstCfgCyc = -1;
    step();
    cfgReqValid  = 1'b1;
    cfgReqWorker = 2'd2;
    cfgReqImage  = 2'd1;
    #2;
    while (!cfgReqReady) begin @(negedge clk); #3; end
    step();
    cfgReqValid = 1'b0;
    #2;
    chk(cfgReqReady == 1'b0, "R5 closed", 32'(cfgReqReady), 0);

    // R7 R12 work skips worker 2 while others continue
    sendWorkChk(15'h1111, 3, "R7/R12 skip");
    sendWorkChk(15'h2222, 0, "R12 others");
    sendWorkChk(15'h3333, 1, "R12 others");
    sendWorkChk(15'h4444, 3, "R7 skip again");

    // R10 wrong channel during streaming
    sendId(1, 2'd1);
    chk(idError == 1'b1, "R10 flag", 32'(idError), 1);
    chk(lastCycles == 0, "R10 ignored", lastCycles, 0);

    while (logN[2] < expN[2] + 8) begin @(negedge clk); #3; end
    #10;
    chk(logN[2] == expN[2] + 8, "R6 count", 32'(logN[2]), 32'(expN[2] + 8));
    for (int i = 0; i < 8; i++)
      chk(logD[2][expN[2] + i] == imgWord(1, i), "R6 image word",
          32'(logD[2][expN[2] + i]), 32'(imgWord(1, i)));
    expN[2] += 8;

    // R10 wrong value on the right channel
    sendId(2, 2'd3);
    chk(cfgReqReady == 1'b0 && lastCycles == 0, "R10 wrong value ignored",
        lastCycles, 0);
    chk(idError == 1'b1, "R10 sticky", 32'(idError), 1);

    // R8 R11 completion
    sendId(2, 2'd2);
    chk(lastCycles == 32'(idCyc - firstCfgCyc), "R11 cycles", lastCycles,
        32'(idCyc - firstCfgCyc));
    chk(lastWorker == 2'd2, "R11 worker", 32'(lastWorker), 2);
    chk(cfgReqReady == 1'b1, "R8 request port reopened", 32'(cfgReqReady), 1);

    sendWorkChk(15'h5050, 0, "R8 order");
    sendWorkChk(15'h5151, 1, "R8 order");
    sendWorkChk(15'h5252, 2, "R8 rejoined");
    sendWorkChk(15'h5353, 3, "R8 order");
    chk(lastCycles == 32'(idCyc - firstCfgCyc), "R11 held", lastCycles,
        32'(idCyc - firstCfgCyc));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule